// File: doc/BRIEF.md
# Stream Configuration Cache

This block sits in front of the configuration decoder of an I/O memory management unit. Each incoming stream of device traffic has a translation configuration that is costly to build: its stream and context descriptors must be fetched and decoded. The cache keeps up to eight decoded configurations, each tagged by stream ID. A requester asks for the configuration of a stream. On a hit the stored copy comes back one cycle later. On a miss the block raises a decode request on its decoder port, waits for the answer and passes the answer on. The answer is stored only when the decoder reports success.

A command port removes stale entries after software changes the tables in memory. It can remove one stream, an aligned run of streams whose length is a power of two, or the entry of one stream because its context descriptors changed. An invalidation command that carries the secure flag is refused with an illegal-command code. Prefetch hints are accepted and have no effect. A hit counter and a miss counter are kept for each stream, and any stream's counters can be read through a select input.

Top module: `stream_cfg_cache`

## Requirements
- R1: Reset marks every slot invalid, clears all counters, and leaves `rsp_valid`, `dec_req` and `cmd_done` low with `lk_ready` high. The first lookup of any stream after a reset is a miss.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. If the stream is cached, the cycle after acceptance shows `rsp_valid`, `rsp_ok` and `rsp_hit` high and `rsp_cfg` equal to the stored configuration. No decode request is raised, and the stream's hit counter increases by one.
- R3: An accepted lookup of an uncached stream increases that stream's miss counter by one. From the next cycle, `dec_req` stays high and `dec_sid` holds the stream, with `lk_ready` low, until the cycle in which `dec_done` is seen.
- R4: The cycle after `dec_done` is seen, `rsp_valid` is high, `rsp_hit` is low, `rsp_ok` equals `dec_ok`, and `rsp_cfg` equals `dec_cfg` when `dec_ok` is high. The configuration is stored only when `dec_ok` is high, so a failed decode leaves the next lookup of that stream a miss.
- R5: Command op 2 (single stream) removes the entry whose tag equals `cmd_sid`. If no such entry exists, the command completes with `cmd_err` = 0.
- R6: Command op 3 (range) removes every entry whose tag t satisfies `cmd_sid` <= t <= `cmd_sid` + 2^(`cmd_range`+1) − 1. The bound is computed without wrap.
- R7: Command op 4 (one context descriptor) and op 5 (all context descriptors) each remove the entire cached entry of `cmd_sid`.
- R8: Any of ops 2 to 5 with `cmd_secure` high changes no entry and completes with `cmd_err` = 1 (illegal).
- R9: Op 0 (prefetch configuration), op 1 (prefetch address) and the unused codes 6 and 7 complete with `cmd_err` = 0 and change no entry, whatever the secure flag.
- R10: `cmd_ready` is always high. Each accepted command gives a one-cycle `cmd_done` pulse in the next cycle, and the pulse carries `cmd_err`.
- R11: A successful fill goes into the lowest-numbered free slot. When no slot is free, it replaces the slot selected by a round-robin pointer. The pointer starts at 0 after reset and moves to the next slot, wrapping, after each such replacement.
- R12: An invalidation that covers a stream takes priority over a lookup of that stream in the same cycle, and the lookup is then handled as a miss. An invalidation that covers the stream of a pending decode, either during the wait or in the `dec_done` cycle, discards that fill. The response still carries the decoder's answer.
- R13: `cnt_hits` and `cnt_misses` show, combinationally, the hit and miss counts of stream `cnt_sel`. The counts wrap at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted (no decode pending) |
| lk_sid | input | SID_W | Stream to look up |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_ok | output | 1 | Configuration available |
| rsp_hit | output | 1 | Response served from the cache |
| rsp_cfg | output | CFG_W | Decoded configuration |
| dec_req | output | 1 | Decode request, held until answered |
| dec_sid | output | SID_W | Stream to decode |
| dec_done | input | 1 | Decoder answer strobe |
| dec_ok | input | 1 | Decode succeeded |
| dec_cfg | input | CFG_W | Decoded configuration |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code |
| cmd_sid | input | SID_W | Stream, or range start |
| cmd_range | input | RNG_W | Range field |
| cmd_secure | input | 1 | Secure-stream flag |
| cmd_done | output | 1 | Command completion pulse |
| cmd_err | output | 2 | 0 none, 1 illegal command |
| cnt_sel | input | SID_W | Stream whose counters are shown |
| cnt_hits | output | CNT_W | Hit count of `cnt_sel` |
| cnt_misses | output | CNT_W | Miss count of `cnt_sel` |

## Verification
The bench targets the three places where an invalidation can meet a lookup: in the acceptance cycle, during the decode wait, and in the cycle the decoder answers. A design that checks the tag before applying the invalidation returns a stale hit in the first case. A design that drops the pending-discard flag fills a stale entry in the other two, and a later lookup then hits where it should miss. It also covers a failed decode, which must not leave an entry behind, and the range bound 2^(range+1) − 1, where an off-by-one keeps or kills the stream just past the boundary. With 16 streams competing for 8 slots, round-robin replacement and the free-slot choice are exercised: a wrong victim shows up as a hit or miss on the wrong stream. The per-stream counters are compared after every phase.

// File: rtl/stream_cfg_cache.sv
module stream_cfg_cache #(
  parameter int SID_W   = 4,
  parameter int CFG_W   = 32,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16,
  parameter int RNG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [SID_W-1:0] lk_sid,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic             rsp_hit,
  output logic [CFG_W-1:0] rsp_cfg,
  output logic             dec_req,
  output logic [SID_W-1:0] dec_sid,
  input  logic             dec_done,
  input  logic             dec_ok,
  input  logic [CFG_W-1:0] dec_cfg,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [SID_W-1:0] cmd_sid,
  input  logic [RNG_W-1:0] cmd_range,
  input  logic             cmd_secure,
  output logic             cmd_done,
  output logic [1:0]       cmd_err,
  input  logic [SID_W-1:0] cnt_sel,
  output logic [CNT_W-1:0] cnt_hits,
  output logic [CNT_W-1:0] cnt_misses
);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int NSTR   = 1 << SID_W;
  localparam int SPAN_W = SID_W + (1 << RNG_W) + 2;

  localparam logic [2:0] OP_INV_STR = 3'd2;
  localparam logic [2:0] OP_INV_RNG = 3'd3;
  localparam logic [2:0] OP_INV_CTX = 3'd4;
  localparam logic [2:0] OP_INV_ALL = 3'd5;

  logic [ENTRIES-1:0] vld;
  logic [SID_W-1:0]   tag [ENTRIES];
  logic [CFG_W-1:0]   cfg [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic               waiting, drop;
  logic [SID_W-1:0]   pend_sid;
  logic [CNT_W-1:0]   hit_cnt  [NSTR];
  logic [CNT_W-1:0]   miss_cnt [NSTR];

  logic               inv_cmd, inv_go, inv_rng;
  logic [SPAN_W-1:0]  rng_lo, rng_hi;
  logic               hit_any, free_any;
  logic [IDX_W-1:0]   hit_idx, free_idx, victim;
  logic               lk_go, lk_kill, lk_hit, pend_kill, dec_fin, fill;

  function automatic logic covers(input logic [SID_W-1:0] t, input logic go,
                                  input logic rng, input logic [SID_W-1:0] s,
                                  input logic [SPAN_W-1:0] lo,
                                  input logic [SPAN_W-1:0] hi);
    logic [SPAN_W-1:0] te;
    te = SPAN_W'(t);
    return go && (rng ? (te >= lo && te <= hi) : (t == s));
  endfunction

  assign inv_cmd = cmd_valid && (cmd_op == OP_INV_STR || cmd_op == OP_INV_RNG ||
                                 cmd_op == OP_INV_CTX || cmd_op == OP_INV_ALL);
  assign inv_go  = inv_cmd && !cmd_secure;
  assign inv_rng = cmd_op == OP_INV_RNG;
  assign rng_lo  = SPAN_W'(cmd_sid);
  assign rng_hi  = rng_lo + (SPAN_W'(1) << ({1'b0, cmd_range} + {{RNG_W{1'b0}}, 1'b1}))
                   - SPAN_W'(1);

  assign lk_ready  = !waiting;
  assign cmd_ready = 1'b1;
  assign dec_req   = waiting;
  assign dec_sid   = pend_sid;
  assign cnt_hits   = hit_cnt[cnt_sel];
  assign cnt_misses = miss_cnt[cnt_sel];

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && tag[i] == lk_sid) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  assign victim    = free_any ? free_idx : rr;
  assign lk_go     = lk_valid && !waiting;
  assign lk_kill   = covers(lk_sid, inv_go, inv_rng, cmd_sid, rng_lo, rng_hi);
  assign lk_hit    = hit_any && !lk_kill;
  assign pend_kill = covers(pend_sid, inv_go, inv_rng, cmd_sid, rng_lo, rng_hi);
  assign dec_fin   = waiting && dec_done;
  assign fill      = dec_fin && dec_ok && !drop && !pend_kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      rr        <= '0;
      waiting   <= 1'b0;
      drop      <= 1'b0;
      pend_sid  <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_cfg   <= '0;
      cmd_done  <= 1'b0;
      cmd_err   <= 2'd0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        cfg[i] <= '0;
      end
      for (int s = 0; s < NSTR; s++) begin
        hit_cnt[s]  <= '0;
        miss_cnt[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      cmd_done  <= cmd_valid;
      cmd_err   <= (inv_cmd && cmd_secure) ? 2'd1 : 2'd0;

      for (int i = 0; i < ENTRIES; i++)
        if (vld[i] && covers(tag[i], inv_go, inv_rng, cmd_sid, rng_lo, rng_hi))
          vld[i] <= 1'b0;

      if (fill) begin
        vld[victim] <= 1'b1;
        tag[victim] <= pend_sid;
        cfg[victim] <= dec_cfg;
        if (!free_any)
          rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + IDX_W'(1);
      end

      if (lk_go) begin
        if (lk_hit) begin
          rsp_valid        <= 1'b1;
          rsp_ok           <= 1'b1;
          rsp_hit          <= 1'b1;
          rsp_cfg          <= cfg[hit_idx];
          hit_cnt[lk_sid]  <= hit_cnt[lk_sid] + CNT_W'(1);
        end else begin
          miss_cnt[lk_sid] <= miss_cnt[lk_sid] + CNT_W'(1);
          waiting          <= 1'b1;
          drop             <= 1'b0;
          pend_sid         <= lk_sid;
        end
      end

      if (waiting && !dec_done && pend_kill)
        drop <= 1'b1;

      if (dec_fin) begin
        waiting   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_ok    <= dec_ok;
        rsp_hit   <= 1'b0;
        rsp_cfg   <= dec_ok ? dec_cfg : '0;
      end
    end
  end
endmodule

// File: rtl/stream_cfg_cache_chk.sv
module stream_cfg_cache_chk #(
  parameter int SID_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             rsp_hit,
  input logic             dec_req,
  input logic [SID_W-1:0] dec_sid,
  input logic             dec_done,
  input logic             dec_ok,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             cmd_secure,
  input logic             cmd_done,
  input logic [1:0]       cmd_err
);
  // R3
  lookup_path_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_ready |=> (rsp_valid != dec_req));

  // R3
  dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dec_req && !dec_done |=> dec_req && $stable(dec_sid));

  // R4
  dec_answer_chk: assert property (@(posedge clk) disable iff (rst)
    dec_req && dec_done |=> rsp_valid && !rsp_hit && (rsp_ok == $past(dec_ok)));

  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> cmd_done);

  // R10
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !cmd_done);

  // R8
  secure_ill_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_secure && cmd_op >= 3'd2 && cmd_op <= 3'd5 |=> cmd_err == 2'd1);

  // R9
  prefetch_ok_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op <= 3'd1 |=> cmd_err == 2'd0);

  // R2
  hit_ok_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> rsp_ok);
endmodule

bind stream_cfg_cache stream_cfg_cache_chk #(.SID_W(SID_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_hit(rsp_hit),
  .dec_req(dec_req), .dec_sid(dec_sid), .dec_done(dec_done), .dec_ok(dec_ok),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_secure(cmd_secure), .cmd_done(cmd_done), .cmd_err(cmd_err)
);

// File: tb/stream_cfg_cache_bench.sv
module stream_cfg_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_ready;
  logic [3:0]  lk_sid = '0;
  logic        rsp_valid, rsp_ok, rsp_hit;
  logic [31:0] rsp_cfg;
  logic        dec_req;
  logic [3:0]  dec_sid;
  logic        dec_done = 1'b0, dec_ok = 1'b0;
  logic [31:0] dec_cfg = '0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [3:0]  cmd_sid = '0;
  logic [2:0]  cmd_range = '0;
  logic        cmd_secure = 1'b0;
  logic        cmd_done;
  logic [1:0]  cmd_err;
  logic [3:0]  cnt_sel = '0;
  logic [15:0] cnt_hits, cnt_misses;

  always #4 clk = ~clk;

  stream_cfg_cache u_stream_cfg_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_sid(lk_sid),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_hit(rsp_hit), .rsp_cfg(rsp_cfg),
    .dec_req(dec_req), .dec_sid(dec_sid), .dec_done(dec_done), .dec_ok(dec_ok),
    .dec_cfg(dec_cfg), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_sid(cmd_sid), .cmd_range(cmd_range), .cmd_secure(cmd_secure),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cnt_sel(cnt_sel),
    .cnt_hits(cnt_hits), .cnt_misses(cnt_misses)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit          mv [8];
  int          mtag [8];
  logic [31:0] mcfg [8];
  int          mrr;
  int          mh [16], mm [16];
  int          gen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void m_clear();
    for (int i = 0; i < 8; i++) mv[i] = 0;
    for (int s = 0; s < 16; s++) begin mh[s] = 0; mm[s] = 0; end
    mrr = 0;
  endfunction

  function automatic int m_find(input int sid);
    for (int i = 0; i < 8; i++) if (mv[i] && mtag[i] == sid) return i;
    return -1;
  endfunction

  function automatic bit m_covers(input int t, input int op, input int s,
                                  input int rg, input bit sec);
    if (op < 2 || op > 5 || sec) return 0;
    if (op == 3) return (t >= s) && (t <= s + (1 << (rg + 1)) - 1);
    return t == s;
  endfunction

  function automatic void m_inv(input int op, input int s, input int rg, input bit sec);
    for (int i = 0; i < 8; i++) if (mv[i] && m_covers(mtag[i], op, s, rg, sec)) mv[i] = 0;
  endfunction

  // returns slot, +8 when the slot was taken by replacement
  function automatic int m_victim();
    for (int i = 0; i < 8; i++) if (!mv[i]) return i;
    return mrr + 8;
  endfunction

  function automatic void m_place(input int v, input int sid, input logic [31:0] c);
    int slot;
    slot = v % 8;
    mv[slot] = 1; mtag[slot] = sid; mcfg[slot] = c;
    if (v >= 8) mrr = (mrr + 1) % 8;
  endfunction

  task automatic drive_cmd(input int op, input int s, input int rg, input bit sec);
    cmd_valid = 1; cmd_op = op[2:0]; cmd_sid = s[3:0]; cmd_range = rg[2:0]; cmd_secure = sec;
  endtask

  task automatic chk_cmd(input int op, input bit sec);
    int exp_err;
    exp_err = (op >= 2 && op <= 5 && sec) ? 1 : 0;
    chk(cmd_done === 1'b1, "R10", "cmd_done", cmd_done, 1);
    chk(cmd_err == exp_err[1:0], exp_err ? "R8" : "R9", "cmd_err", cmd_err, exp_err);
  endtask

  task automatic send_cmd(input int op, input int s, input int rg, input bit sec);
    @(negedge clk);
    drive_cmd(op, s, rg, sec);
    @(negedge clk);
    cmd_valid = 0;
    chk_cmd(op, sec);
    m_inv(op, s, rg, sec);
  endtask

  // cmode: 0 none, 1 command with the lookup, 2 command during the wait, 3 command with dec_done
  task automatic lookup(input int sid, input bit fail, input int dly, input int cmode,
                        input int op, input int cs, input int rg, input bit sec);
    int idx, v;
    bit kill, exp_hit, drop;
    logic [31:0] c;
    @(negedge clk);
    lk_valid = 1; lk_sid = sid[3:0];
    if (cmode == 1) drive_cmd(op, cs, rg, sec);
    kill = (cmode == 1) && m_covers(sid, op, cs, rg, sec);
    idx = m_find(sid);
    exp_hit = (idx >= 0) && !kill;
    @(negedge clk);
    lk_valid = 0;
    if (cmode == 1) begin cmd_valid = 0; chk_cmd(op, sec); m_inv(op, cs, rg, sec); end
    if (exp_hit) begin
      mh[sid]++;
      chk(rsp_valid && rsp_hit && rsp_ok, "R2", "hit flags", {rsp_valid, rsp_hit, rsp_ok}, 7);
      chk(rsp_cfg == mcfg[idx], "R2", "hit cfg", rsp_cfg, mcfg[idx]);
      chk(!dec_req, kill ? "R12" : "R2", "no decode on hit", dec_req, 0);
    end else begin
      mm[sid]++;
      chk(!rsp_valid && dec_req && dec_sid == sid[3:0] && !lk_ready,
          kill ? "R12" : "R3", "miss decode req", {rsp_valid, dec_req, dec_sid}, {2'b01, sid[3:0]});
      drop = 0;
      if (cmode == 2 && dly < 1) dly = 1;
      for (int k = 0; k < dly; k++) begin
        if (cmode == 2 && k == 0) drive_cmd(op, cs, rg, sec);
        @(negedge clk);
        if (cmode == 2 && k == 0) begin
          cmd_valid = 0; chk_cmd(op, sec);
          if (m_covers(sid, op, cs, rg, sec)) drop = 1;
          m_inv(op, cs, rg, sec);
        end
        chk(dec_req && dec_sid == sid[3:0], "R3", "decode held", {dec_req, dec_sid}, {1'b1, sid[3:0]});
      end
      gen++;
      c = {sid[7:0], gen[23:0]};
      dec_done = 1; dec_ok = !fail; dec_cfg = c;
      if (cmode == 3) begin
        drive_cmd(op, cs, rg, sec);
        if (m_covers(sid, op, cs, rg, sec)) drop = 1;
      end
      v = m_victim();
      @(negedge clk);
      dec_done = 0;
      if (cmode == 3) begin cmd_valid = 0; chk_cmd(op, sec); m_inv(op, cs, rg, sec); end
      chk(rsp_valid && !rsp_hit && rsp_ok == !fail, "R4", "decode response",
          {rsp_valid, rsp_hit, rsp_ok}, {2'b10, !fail});
      if (!fail) chk(rsp_cfg == c, "R4", "decode cfg", rsp_cfg, c);
      if (!fail && !drop) m_place(v, sid, c);
    end
  endtask

  task automatic chk_counts();
    for (int s = 0; s < 16; s++) begin
      cnt_sel = s[3:0];
      #1;
      chk(cnt_hits == mh[s][15:0], "R13", $sformatf("hits of %0d", s), cnt_hits, mh[s]);
      chk(cnt_misses == mm[s][15:0], "R13", $sformatf("misses of %0d", s), cnt_misses, mm[s]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    m_clear();
    // R1
    chk(!rsp_valid && !dec_req && !cmd_done && lk_ready, "R1", "reset outputs",
        {rsp_valid, dec_req, cmd_done, lk_ready}, 1);
    chk_counts();
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed1234);
    m_clear();
    do_reset();

    // R3 R4 miss then fill, R2 hit
    lookup(3, 0, 2, 0, 0, 0, 0, 0);
    lookup(3, 0, 1, 0, 0, 0, 0, 0);
    // R4 failed decode stores nothing
    lookup(5, 1, 1, 0, 0, 0, 0, 0);
    lookup(5, 0, 3, 0, 0, 0, 0, 0);
    lookup(5, 0, 1, 0, 0, 0, 0, 0);
    // R5 single stream removal and absent stream
    send_cmd(2, 3, 0, 0);
    lookup(3, 0, 1, 0, 0, 0, 0, 0);
    send_cmd(2, 9, 0, 0);
    // R11 fill all slots, then replacement by round robin
    for (int s = 8; s < 15; s++) lookup(s, 0, 1, 0, 0, 0, 0, 0);
    lookup(0, 0, 1, 0, 0, 0, 0, 0);
    lookup(1, 0, 1, 0, 0, 0, 0, 0);
    for (int s = 0; s < 16; s++) lookup(s, 0, 1, 0, 0, 0, 0, 0);
    // R6 range removal boundary
    for (int s = 4; s < 8; s++) lookup(s, 0, 1, 0, 0, 0, 0, 0);
    send_cmd(3, 4, 0, 0);
    lookup(6, 0, 1, 0, 0, 0, 0, 0);
    lookup(5, 0, 1, 0, 0, 0, 0, 0);
    lookup(4, 0, 1, 0, 0, 0, 0, 0);
    send_cmd(3, 0, 7, 0);
    lookup(6, 0, 1, 0, 0, 0, 0, 0);
    // R7 context removals
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    send_cmd(4, 2, 0, 0);
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    send_cmd(5, 2, 0, 0);
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    // R8 secure invalidations refused, entry survives
    for (int op = 2; op < 6; op++) send_cmd(op, 2, 3, 1);
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    // R9 prefetch and unused codes have no effect
    send_cmd(0, 2, 0, 1);
    send_cmd(1, 2, 0, 0);
    send_cmd(6, 2, 0, 0);
    send_cmd(7, 2, 0, 1);
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    // R12 conflicts
    lookup(2, 0, 1, 1, 2, 2, 0, 0);
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    lookup(7, 0, 2, 2, 2, 7, 0, 0);
    lookup(7, 0, 1, 0, 0, 0, 0, 0);
    lookup(7, 0, 1, 0, 0, 0, 0, 0);
    lookup(9, 0, 1, 3, 3, 8, 0, 0);
    lookup(9, 0, 1, 0, 0, 0, 0, 0);
    lookup(9, 0, 1, 3, 2, 1, 0, 0);
    lookup(9, 0, 1, 0, 0, 0, 0, 0);
    chk_counts();

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 10 < 7) begin
        lookup($urandom % 16, ($urandom % 6) == 0, 1 + $urandom % 3,
               (($urandom % 6) == 0) ? 1 + $urandom % 3 : 0,
               $urandom % 8, $urandom % 16, $urandom % 3, ($urandom % 5) == 0);
      end else begin
        send_cmd($urandom % 8, $urandom % 16, $urandom % 3, ($urandom % 5) == 0);
      end
    end
    chk_counts();

    // R1 reset mid-run empties the cache
    do_reset();
    lookup(2, 0, 1, 0, 0, 0, 0, 0);
    chk_counts();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule